// File: doc/BRIEF.md
# ADC Pre-Trigger Sequencing Channel

This block drives the conversion requests of one ADC channel. It holds a set of pre-trigger slots, eight by default. Each slot can fire in one of two ways. In compare mode it fires when a shared delay counter reaches the slot's own delay value. In chained mode it fires when the conversion of the slot before it completes. Each time a slot fires, the block pulses a one-clock valid strobe and a channel trigger, and it presents the index of the slot that fired, so the converter knows which configuration and result set to use.

The delay values are written into a shadow bank. They reach the comparators only when a load strobe is given, so a whole set of delays can be changed together between counter periods. The enable, compare and chained masks take effect on the clock after they are written.

The block keeps one sticky match flag per slot. It also keeps one sticky sequence-error flag per slot, which marks a slot that fired while a lower-numbered slot was still waiting for its conversion to finish. Software clears these flags by writing 0 to a bit. The sequence-error interrupt is the OR of the error flags, gated by an enable input.

Top module: `adc_pretrig_chan`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, pre_vld, chan_trig, pre_sel, match_flag, err_flag and seq_err_irq are all 0. Every active delay value resets to 0, and no slot is armed for a compare.
- R2: A slot in compare mode (enable bit set, chained bit clear, compare bit set) fires in a cycle when it is armed and cnt_val equals its active delay. A slot is armed from a cycle in which cnt_start is high, counting that cycle itself, until it fires. It therefore fires at most once per counter period.
- R3: A slot in chained mode (enable bit set, chained bit set) fires in the cycle when conv_done of the slot before it is high, whatever the counter shows. Slot i chains from slot i-1, and slot 0 chains from slot NUM_PRE-1.
- R4: pre_vld and chan_trig are high for exactly the one cycle after a cycle in which any slot fires. pre_sel then holds the lowest index among the slots that fired. When pre_vld is low, pre_sel is 0.
- R5: A write with dly_we stores dly_val into the shadow entry dly_idx only. On load_ok, every active delay takes the value its shadow entry held before that clock edge. Until then, compares use the old active value.
- R6: match_flag bit i sets when slot i fires and stays set. On a flag_we cycle, each bit whose match_keep bit is 0 clears, unless the same slot fires in that cycle, in which case setting wins.
- R7: err_flag bit i sets when slot i fires while a lower-numbered slot is still outstanding or fires in the same cycle. A slot is outstanding from the cycle after it fires until a cycle in which its own conv_done is high. A conv_done in the same cycle as the firing already counts as complete. Clearing works as in R6, using err_keep.
- R8: seq_err_irq is high exactly when seq_err_ie is high and at least one err_flag bit is set.
- R9: A slot whose enable bit is clear never fires, and neither does an enabled slot with both its compare bit and its chained bit clear. Such a slot sets no flag and drives no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | DLY_W | Shared delay counter value |
| cnt_start | input | 1 | High in the first cycle of a counter period; arms compare slots |
| conv_done | input | NUM_PRE | Per-slot conversion-complete pulse |
| cfg_we | input | 1 | Writes the three mode masks |
| cfg_en | input | NUM_PRE | Slot enable mask |
| cfg_os | input | NUM_PRE | Compare-mode select mask |
| cfg_bb | input | NUM_PRE | Chained-mode select mask |
| dly_we | input | 1 | Writes one shadow delay entry |
| dly_idx | input | IDX_W | Shadow delay entry index |
| dly_val | input | DLY_W | Shadow delay value |
| load_ok | input | 1 | Copies all shadow delays into the active delays |
| flag_we | input | 1 | Flag write strobe; a 0 bit clears its flag |
| match_keep | input | NUM_PRE | Match flag write data |
| err_keep | input | NUM_PRE | Error flag write data |
| seq_err_ie | input | 1 | Sequence-error interrupt enable |
| pre_sel | output | IDX_W | Index of the slot that fired |
| pre_vld | output | 1 | One-cycle pre-trigger valid |
| chan_trig | output | 1 | One-cycle channel trigger |
| match_flag | output | NUM_PRE | Sticky per-slot match flags |
| err_flag | output | NUM_PRE | Sticky per-slot sequence-error flags |
| seq_err_irq | output | 1 | Sequence-error interrupt |

## Verification
The bench targets four cases: the wrap of the chain from the highest slot back to slot 0, a compare delay that is written but not yet loaded, a counter that stays on a matching value, and a chained slot that fires while a lower slot is still waiting for its conversion. A design that chained slot 0 from nothing would go silent after the last slot. One that compared against the shadow delay would fire early. One that did not disarm would fire on every cycle the counter stays at the matching value. One that ignored outstanding slots would never raise err_flag or the interrupt. The bench also covers a clear that happens in the same cycle as a set, and a conv_done that arrives in the very cycle its successor fires, which must not count as an overlap.

// File: rtl/adc_pretrig_pkg.sv
package adc_pretrig_pkg;

  // How a single slot decides to fire.
  typedef enum logic [1:0] {
    SRC_OFF   = 2'd0,
    SRC_CMP   = 2'd1,
    SRC_CHAIN = 2'd2
  } fire_src_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/apt_dly_bank.sv
module apt_dly_bank #(
  parameter int unsigned NUM_PRE = 8,
  parameter int unsigned DLY_W   = 16,
  parameter int unsigned IDX_W   = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [DLY_W-1:0]                wr_val,
  input  logic                            load_ok,
  output logic [NUM_PRE-1:0][DLY_W-1:0]   dly_act
);

  for (genvar gi = 0; gi < NUM_PRE; gi++) begin : g_entry
    logic [DLY_W-1:0] shadow_q, shadow_d;
    logic             shadow_en;
    logic [DLY_W-1:0] act_q, act_d;

    always_comb begin
      shadow_en = wr_en && (wr_idx == IDX_W'(gi));
      shadow_d  = wr_val;
      act_d     = shadow_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= '0;
      end else if (shadow_en) begin
        shadow_q <= shadow_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q <= '0;
      end else if (load_ok) begin
        act_q <= act_d;
      end
    end

    assign dly_act[gi] = act_q;
  end

endmodule

// File: rtl/apt_slot.sv
module apt_slot
  import adc_pretrig_pkg::*;
#(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             use_cmp,
  input  logic             use_chain,
  input  logic [DLY_W-1:0] cnt_val,
  input  logic             cnt_start,
  input  logic [DLY_W-1:0] dly,
  input  logic             prev_done,
  input  logic             own_done,
  output logic             fire,
  output logic             pend
);

  fire_src_e src;
  logic      armed_q, armed_d, arm_upd;
  logic      out_q, out_d, out_upd;
  logic      hit;

  always_comb begin
    if (!en)            src = SRC_OFF;
    else if (use_chain) src = SRC_CHAIN;
    else if (use_cmp)   src = SRC_CMP;
    else                src = SRC_OFF;

    hit = (src == SRC_CMP) && (armed_q || cnt_start) && (cnt_val == dly);

    case (src)
      SRC_CHAIN: fire = prev_done;
      SRC_CMP:   fire = hit;
      default:   fire = 1'b0;
    endcase

    arm_upd = cnt_start | hit;
    armed_d = (armed_q | cnt_start) & ~hit;

    pend    = out_q & ~own_done;
    out_upd = own_done | fire;
    out_d   = pend | fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (arm_upd) begin
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else if (out_upd) begin
      out_q <= out_d;
    end
  end

endmodule

// File: rtl/apt_flags.sv
module apt_flags #(
  parameter int unsigned NUM_PRE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_PRE-1:0] fire,
  input  logic [NUM_PRE-1:0] err_set,
  input  logic               wr_en,
  input  logic [NUM_PRE-1:0] cf_wdata,
  input  logic [NUM_PRE-1:0] ef_wdata,
  output logic [NUM_PRE-1:0] cf,
  output logic [NUM_PRE-1:0] ef
);

  logic [NUM_PRE-1:0] cf_q, cf_d, ef_q, ef_d;
  logic               cf_upd, ef_upd;

  always_comb begin
    cf_upd = wr_en | (|fire);
    ef_upd = wr_en | (|err_set);
    cf_d   = (wr_en ? (cf_q & cf_wdata) : cf_q) | fire;
    ef_d   = (wr_en ? (ef_q & ef_wdata) : ef_q) | err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cf_q <= '0;
    end else if (cf_upd) begin
      cf_q <= cf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ef_q <= '0;
    end else if (ef_upd) begin
      ef_q <= ef_d;
    end
  end

  assign cf = cf_q;
  assign ef = ef_q;

endmodule

// File: rtl/adc_pretrig_chan.sv
module adc_pretrig_chan
  import adc_pretrig_pkg::*;
#(
  parameter int unsigned NUM_PRE = 8,
  parameter int unsigned DLY_W   = 16,
  localparam int unsigned IDX_W  = idx_width(NUM_PRE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DLY_W-1:0]   cnt_val,
  input  logic               cnt_start,
  input  logic [NUM_PRE-1:0] conv_done,
  input  logic               cfg_we,
  input  logic [NUM_PRE-1:0] cfg_en,
  input  logic [NUM_PRE-1:0] cfg_os,
  input  logic [NUM_PRE-1:0] cfg_bb,
  input  logic               dly_we,
  input  logic [IDX_W-1:0]   dly_idx,
  input  logic [DLY_W-1:0]   dly_val,
  input  logic               load_ok,
  input  logic               flag_we,
  input  logic [NUM_PRE-1:0] match_keep,
  input  logic [NUM_PRE-1:0] err_keep,
  input  logic               seq_err_ie,
  output logic [IDX_W-1:0]   pre_sel,
  output logic               pre_vld,
  output logic               chan_trig,
  output logic [NUM_PRE-1:0] match_flag,
  output logic [NUM_PRE-1:0] err_flag,
  output logic               seq_err_irq
);

  // Mode masks, live one clock after the write.
  logic [NUM_PRE-1:0] en_q, os_q, bb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      os_q <= '0;
      bb_q <= '0;
    end else if (cfg_we) begin
      en_q <= cfg_en;
      os_q <= cfg_os;
      bb_q <= cfg_bb;
    end
  end

  logic [NUM_PRE-1:0][DLY_W-1:0] dly_act;

  apt_dly_bank #(
    .NUM_PRE (NUM_PRE),
    .DLY_W   (DLY_W),
    .IDX_W   (IDX_W)
  ) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (dly_we),
    .wr_idx  (dly_idx),
    .wr_val  (dly_val),
    .load_ok (load_ok),
    .dly_act (dly_act)
  );

  logic [NUM_PRE-1:0] fire, pend, busy, err_set;

  for (genvar gi = 0; gi < NUM_PRE; gi++) begin : g_slot
    localparam int unsigned PREV = (gi == 0) ? NUM_PRE - 1 : gi - 1;

    apt_slot #(
      .DLY_W (DLY_W)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_q[gi]),
      .use_cmp   (os_q[gi]),
      .use_chain (bb_q[gi]),
      .cnt_val   (cnt_val),
      .cnt_start (cnt_start),
      .dly       (dly_act[gi]),
      .prev_done (conv_done[PREV]),
      .own_done  (conv_done[gi]),
      .fire      (fire[gi]),
      .pend      (pend[gi])
    );
  end

  assign busy = pend | fire;

  // A slot overlaps when any lower slot is still busy.
  for (genvar gi = 0; gi < NUM_PRE; gi++) begin : g_err
    localparam logic [NUM_PRE-1:0] BELOW = (NUM_PRE'(1) << gi) - NUM_PRE'(1);
    assign err_set[gi] = fire[gi] & (|(busy & BELOW));
  end

  apt_flags #(
    .NUM_PRE (NUM_PRE)
  ) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .err_set  (err_set),
    .wr_en    (flag_we),
    .cf_wdata (match_keep),
    .ef_wdata (err_keep),
    .cf       (match_flag),
    .ef       (err_flag)
  );

  // Lowest firing index wins the select lines.
  logic [IDX_W-1:0] sel_d, sel_q;
  logic             any_fire, vld_q, trig_q;

  always_comb begin
    sel_d = '0;
    for (int i = NUM_PRE - 1; i >= 0; i--) begin
      if (fire[i]) sel_d = IDX_W'(i);
    end
    any_fire = |fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      vld_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      vld_q  <= any_fire;
      trig_q <= any_fire;
    end
  end

  assign pre_sel     = sel_q;
  assign pre_vld     = vld_q;
  assign chan_trig   = trig_q;
  assign seq_err_irq = seq_err_ie & (|err_flag);

endmodule

// File: rtl/adc_pretrig_chan_chk.sv
module adc_pretrig_chan_chk #(
  parameter int unsigned NUM_PRE = 8,
  parameter int unsigned IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flag_we,
  input logic               seq_err_ie,
  input logic [IDX_W-1:0]   pre_sel,
  input logic               pre_vld,
  input logic [NUM_PRE-1:0] match_flag,
  input logic [NUM_PRE-1:0] err_flag,
  input logic               seq_err_irq
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_idle_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_vld |-> (pre_sel == '0));

  assert_vld_has_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pre_vld |-> match_flag[pre_sel]);

  assert_match_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(flag_we)) |-> ((match_flag & $past(match_flag)) == $past(match_flag)));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(flag_we)) |-> ((err_flag & $past(err_flag)) == $past(err_flag)));

  assert_err_with_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((err_flag & ~$past(err_flag) & ~match_flag) == '0));

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_err_ie |-> !seq_err_irq);

endmodule

bind adc_pretrig_chan adc_pretrig_chan_chk #(
  .NUM_PRE (NUM_PRE),
  .IDX_W   (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flag_we     (flag_we),
  .seq_err_ie  (seq_err_ie),
  .pre_sel     (pre_sel),
  .pre_vld     (pre_vld),
  .match_flag  (match_flag),
  .err_flag    (err_flag),
  .seq_err_irq (seq_err_irq)
);

// File: tb/adc_pretrig_chan_bench.sv
`timescale 1ns/1ps
module adc_pretrig_chan_bench;

  localparam int N  = 8;
  localparam int DW = 16;
  localparam int IW = 3;

  logic          clk, rst_n;
  logic [DW-1:0] cnt_val;
  logic          cnt_start;
  logic [N-1:0]  conv_done;
  logic          cfg_we;
  logic [N-1:0]  cfg_en, cfg_os, cfg_bb;
  logic          dly_we;
  logic [IW-1:0] dly_idx;
  logic [DW-1:0] dly_val;
  logic          load_ok, flag_we;
  logic [N-1:0]  match_keep, err_keep;
  logic          seq_err_ie;
  logic [IW-1:0] pre_sel;
  logic          pre_vld, chan_trig, seq_err_irq;
  logic [N-1:0]  match_flag, err_flag;

  adc_pretrig_chan #(.NUM_PRE(N), .DLY_W(DW)) u_adc_pretrig_chan (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  // Reference state built from the requirements.
  logic [N-1:0]  m_en, m_os, m_bb, m_arm, m_out, m_cf, m_ef;
  logic [DW-1:0] m_sh [N];
  logic [DW-1:0] m_act [N];
  logic          m_vld;
  logic [IW-1:0] m_sel;
  logic [N-1:0]  x_en, x_os, x_bb, x_arm, x_out, x_cf, x_ef;
  logic [DW-1:0] x_sh [N];
  logic [DW-1:0] x_act [N];
  logic          x_vld;
  logic [IW-1:0] x_sel;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = '0; m_os = '0; m_bb = '0; m_arm = '0; m_out = '0;
    m_cf = '0; m_ef = '0; m_vld = 1'b0; m_sel = '0;
    for (int i = 0; i < N; i++) begin m_sh[i] = '0; m_act[i] = '0; end
  endtask

  task automatic model_eval();
    logic [N-1:0] f, pend, busy, es;
    for (int i = 0; i < N; i++) begin
      logic arm_e, hit, chain, cmp;
      chain  = m_en[i] && m_bb[i];
      cmp    = m_en[i] && !m_bb[i] && m_os[i];
      arm_e  = m_arm[i] || cnt_start;
      hit    = cmp && arm_e && (cnt_val == m_act[i]);
      f[i]   = chain ? conv_done[(i + N - 1) % N] : hit;
      x_arm[i] = arm_e && !hit;
      pend[i]  = m_out[i] && !conv_done[i];
    end
    x_out = pend | f;
    busy  = pend | f;
    for (int i = 0; i < N; i++) begin
      logic [N-1:0] below;
      below = N'((1 << i) - 1);
      es[i] = f[i] && ((busy & below) != '0);
    end
    x_vld = |f;
    x_sel = '0;
    for (int i = N - 1; i >= 0; i--) if (f[i]) x_sel = IW'(i);
    x_cf = (flag_we ? (m_cf & match_keep) : m_cf) | f;
    x_ef = (flag_we ? (m_ef & err_keep) : m_ef) | es;
    for (int i = 0; i < N; i++) begin
      x_act[i] = load_ok ? m_sh[i] : m_act[i];
      x_sh[i]  = (dly_we && dly_idx == IW'(i)) ? dly_val : m_sh[i];
    end
    x_en = cfg_we ? cfg_en : m_en;
    x_os = cfg_we ? cfg_os : m_os;
    x_bb = cfg_we ? cfg_bb : m_bb;
  endtask

  task automatic model_commit();
    m_en = x_en; m_os = x_os; m_bb = x_bb; m_arm = x_arm; m_out = x_out;
    m_cf = x_cf; m_ef = x_ef; m_vld = x_vld; m_sel = x_sel;
    for (int i = 0; i < N; i++) begin m_sh[i] = x_sh[i]; m_act[i] = x_act[i]; end
  endtask

  task automatic compare_all();
    check("R4 pre_vld", 32'(pre_vld), 32'(m_vld));
    check("R4 chan_trig", 32'(chan_trig), 32'(m_vld));
    check("R4 pre_sel", 32'(pre_sel), 32'(m_sel));
    check("R6 match_flag", 32'(match_flag), 32'(m_cf));
    check("R7 err_flag", 32'(err_flag), 32'(m_ef));
    check("R8 seq_err_irq", 32'(seq_err_irq), 32'(seq_err_ie && (m_ef != '0)));
  endtask

  task automatic tick();
    model_eval();
    @(posedge clk);
    #1;
    model_commit();
    compare_all();
    cnt_start = 1'b0; conv_done = '0; cfg_we = 1'b0;
    dly_we = 1'b0; load_ok = 1'b0; flag_we = 1'b0;
  endtask

  task automatic set_cfg(input logic [N-1:0] e, input logic [N-1:0] o, input logic [N-1:0] b);
    cfg_we = 1'b1; cfg_en = e; cfg_os = o; cfg_bb = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt_v;
    void'($urandom(32'h1A2B3C4D));
    rst_n = 1'b0; cnt_val = '0; cnt_start = 1'b0; conv_done = '0;
    cfg_we = 1'b0; cfg_en = '0; cfg_os = '0; cfg_bb = '0;
    dly_we = 1'b0; dly_idx = '0; dly_val = '0; load_ok = 1'b0;
    flag_we = 1'b0; match_keep = '0; err_keep = '0; seq_err_ie = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check("R1 pre_vld", 32'(pre_vld), 0);
    check("R1 chan_trig", 32'(chan_trig), 0);
    check("R1 match_flag", 32'(match_flag), 0);
    check("R1 err_flag", 32'(err_flag), 0);
    check("R1 pre_sel", 32'(pre_sel), 0);
    rst_n = 1'b1;
    tick();
    check("R1 idle after release", 32'(pre_vld), 0);

    // R5: shadow write without load does not reach the compare
    dly_we = 1'b1; dly_idx = 3'd2; dly_val = 16'd7;
    set_cfg(8'h04, 8'h04, 8'h00);
    tick();
    cnt_start = 1'b1; cnt_val = 16'd3; tick();
    check("R5 no fire, active still 0", 32'(pre_vld), 0);
    cnt_val = 16'd7; tick();
    check("R5 unloaded delay ignored", 32'(pre_vld), 0);
    load_ok = 1'b1; cnt_val = 16'd8; tick();
    cnt_val = 16'd7; tick();
    check("R2 compare fires", 32'(pre_vld), 1);
    check("R2 compare sel", 32'(pre_sel), 2);
    tick();
    check("R2 fires once per period", 32'(pre_vld), 0);

    // R3: chain wraps from top slot to slot 0
    set_cfg(8'h81, 8'h00, 8'h81); tick();
    conv_done = 8'h80; tick();
    check("R3 slot0 chains from slot7", 32'(pre_vld), 1);
    check("R3 sel 0", 32'(pre_sel), 0);
    conv_done = 8'h40; tick();
    check("R3 slot7 chains from slot6", 32'(pre_sel), 7);
    check("R7 overlap flagged", 32'(err_flag), 32'h80);
    check("R8 irq masked", 32'(seq_err_irq), 0);
    seq_err_ie = 1'b1; tick();
    check("R8 irq enabled", 32'(seq_err_irq), 1);

    // R6: write-zero clear
    flag_we = 1'b1; match_keep = 8'hFB; err_keep = 8'hFF; tick();
    check("R6 clear one bit", 32'(match_flag), 32'h81);

    // R9: disabled or mode-less slots stay quiet
    set_cfg(8'h00, 8'hFF, 8'h00); tick();
    cnt_start = 1'b1; cnt_val = 16'd0; tick();
    check("R9 disabled no fire", 32'(pre_vld), 0);
    set_cfg(8'h01, 8'h00, 8'h00); tick();
    cnt_start = 1'b1; conv_done = 8'h80; tick();
    check("R9 no mode no fire", 32'(pre_vld), 0);
    check("R9 flags unchanged", 32'(match_flag), 32'h81);

    // R7: completion in the same cycle as the successor fires is no overlap
    flag_we = 1'b1; match_keep = '0; err_keep = '0;
    set_cfg(8'h03, 8'h00, 8'h03); tick();
    conv_done = 8'h80; tick();
    conv_done = 8'h01; tick();
    check("R7 done same cycle no error", 32'(err_flag), 0);
    check("R3 slot1 chained", 32'(pre_sel), 1);
    seq_err_ie = 1'b0;

    // Random phase
    cnt_v = 0;
    for (int c = 0; c < 4000; c++) begin
      cnt_val   = DW'(cnt_v);
      cnt_start = (cnt_v == 0);
      cnt_v     = (cnt_v == 39) ? 0 : cnt_v + 1;
      for (int b = 0; b < N; b++) conv_done[b] = ($urandom % 6) == 0;
      if ($urandom % 40 == 0) set_cfg(N'($urandom), N'($urandom), N'($urandom) & N'($urandom));
      if ($urandom % 8 == 0) begin
        dly_we = 1'b1; dly_idx = IW'($urandom); dly_val = DW'($urandom % 48);
      end
      if ($urandom % 25 == 0) load_ok = 1'b1;
      if ($urandom % 15 == 0) begin
        flag_we = 1'b1; match_keep = N'($urandom); err_keep = N'($urandom);
      end
      if ($urandom % 100 == 0) seq_err_ie = ~seq_err_ie;
      tick();
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule